// File: doc/BRIEF.md
# Reset Cause Fault Register

This block keeps a one-byte record of why the system was last reset. Four event inputs come from the reset logic: manual reset, watchdog timeout, and two separate low-voltage detectors. A rising edge on any of them sets its own flag bit. The flag then stays set until software overwrites the register.

Software reaches the register over a serial bus. The bus front end, which is outside this block, parses each transaction and presents it here as one pulse. The pulse carries the slave-byte preamble, the register address, the direction, the number of data bytes and the first data byte.

The register answers only to one preamble at one fixed address. A write needs no prior enable sequence. A write must carry exactly one data byte, and any other count is refused with a NACK.

Top module: `rc_cause_reg`

## Requirements
- R1: After rst_ni is released, fault_o reads 0x00 and rd_valid_o, wr_ack_o and wr_nack_o are all 0.
- R2: A rising edge on an event input sets one flag in fault_o on the clock edge at which the edge is sampled. The flag positions are: lv1_evt_i to bit 7, lv2_evt_i to bit 6, wd_evt_i to bit 4 and mr_evt_i to bit 3.
- R3: A set flag stays set while no accepted write occurs, whatever its input does afterwards. After software clears the flag, a level that is held high does not set it again.
- R4: Bits 5, 2, 1 and 0 of fault_o always read 0, even when a write carries 1s in those positions.
- R5: A transaction is addressed to the register only when txn_pre_i is 4'b1011 and txn_addr_i is 8'hFF. Any other transaction changes nothing and raises no response output.
- R6: A write addressed to the register with txn_len_i equal to 1 replaces the register with txn_data_i, with the unused bits masked. No prior enable write is needed. wr_ack_o pulses for one cycle in the cycle that follows.
- R7: A write addressed to the register with txn_len_i other than 1 (zero or more than one byte) leaves the register unchanged and pulses wr_nack_o for one cycle.
- R8: A read addressed to the register pulses rd_valid_o for one cycle. In that cycle rd_data_o holds the register value from before the edge that accepted the read.
- R9: When an event edge and an accepted write fall in the same cycle, that event's flag ends up set whatever the written data. The other bits take the written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mr_evt_i | input | 1 | Manual reset event level |
| wd_evt_i | input | 1 | Watchdog timeout event level |
| lv1_evt_i | input | 1 | First low-voltage event level |
| lv2_evt_i | input | 1 | Second low-voltage event level |
| txn_valid_i | input | 1 | One-cycle pulse marking a completed bus transaction |
| txn_pre_i | input | 4 | Slave-byte preamble of the transaction |
| txn_addr_i | input | 8 | Register address of the transaction |
| txn_wr_i | input | 1 | 1 for write, 0 for read |
| txn_len_i | input | 4 | Number of data bytes in a write |
| txn_data_i | input | 8 | First data byte of a write |
| fault_o | output | 8 | Current register contents |
| rd_valid_o | output | 1 | Read response pulse |
| rd_data_o | output | 8 | Read response data |
| wr_ack_o | output | 1 | Accepted-write pulse |
| wr_nack_o | output | 1 | Refused-write pulse |

## Verification
The hardest case to bring about is a collision: an accepted write and a rising event edge sampled on the same edge. A read that coincides with an event edge is similar. The stimulus reaches both by driving the event input and the transaction pulse in the same half-cycle, then checking the flag and the pre-edge read data one cycle later.

The held-high event level after a software clear is also hard to reach. The bench clears the register while the input stays high, and confirms that several later cycles show no new flag.

A long stretch of mixed random traffic biased toward the selected preamble and address is then compared every clock against a behavioural model.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int NUM_EVT = 4;
  localparam logic [3:0] SEL_PRE  = 4'b1011;
  localparam logic [7:0] REG_ADDR = 8'hFF;

  // event index order: mr, wd, lv2, lv1
  localparam int EVT_POS [NUM_EVT] = '{3, 4, 6, 7};

  typedef struct packed {
    logic wr_ok;
    logic wr_bad;
    logic rd;
  } dec_t;

  function automatic int evt_of_bit(int b);
    int r;
    r = -1;
    for (int i = 0; i < NUM_EVT; i++)
      if (EVT_POS[i] == b) r = i;
    return r;
  endfunction
endpackage

// File: rtl/rc_edge_det.sv
module rc_edge_det #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= lvl_i[i];
    end
    assign rise_o[i] = lvl_i[i] & ~prev_q;
  end
endmodule

// File: rtl/rc_bus_decode.sv
module rc_bus_decode
  import rc_pkg::*;
#(
  parameter int PRE_W  = 4,
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 4,
  parameter logic [PRE_W-1:0]  PRE_SEL  = SEL_PRE,
  parameter logic [ADDR_W-1:0] ADDR_SEL = REG_ADDR
) (
  input  logic              valid_i,
  input  logic [PRE_W-1:0]  pre_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [LEN_W-1:0]  len_i,
  output dec_t              dec_o
);
  localparam logic [LEN_W-1:0] ONE_BYTE = LEN_W'(1);
  logic hit;

  always_comb begin
    hit          = valid_i && (pre_i == PRE_SEL) && (addr_i == ADDR_SEL);
    dec_o.wr_ok  = hit && wr_i && (len_i == ONE_BYTE);
    dec_o.wr_bad = hit && wr_i && (len_i != ONE_BYTE);
    dec_o.rd     = hit && !wr_i;
  end
endmodule

// File: rtl/rc_flag_reg.sv
module rc_flag_reg
  import rc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int N      = NUM_EVT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      set_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] q_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    localparam int EI = evt_of_bit(b);
    if (EI >= 0) begin : g_flag
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            q <= 1'b0;
        else if (set_i[EI])     q <= 1'b1;      // event wins over write
        else if (wr_en_i)       q <= wr_data_i[b];
      end
      assign q_o[b] = q;
    end else begin : g_zero
      assign q_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/rc_cause_reg.sv
module rc_cause_reg
  import rc_pkg::*;
#(
  parameter int PRE_W  = 4,
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mr_evt_i,
  input  logic              wd_evt_i,
  input  logic              lv1_evt_i,
  input  logic              lv2_evt_i,
  input  logic              txn_valid_i,
  input  logic [PRE_W-1:0]  txn_pre_i,
  input  logic [ADDR_W-1:0] txn_addr_i,
  input  logic              txn_wr_i,
  input  logic [LEN_W-1:0]  txn_len_i,
  input  logic [DATA_W-1:0] txn_data_i,
  output logic [DATA_W-1:0] fault_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              wr_ack_o,
  output logic              wr_nack_o
);
  logic [NUM_EVT-1:0] evt_lvl, evt_rise;
  dec_t dec;

  assign evt_lvl = {lv1_evt_i, lv2_evt_i, wd_evt_i, mr_evt_i};

  rc_edge_det #(.N(NUM_EVT)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (evt_lvl),
    .rise_o(evt_rise)
  );

  rc_bus_decode #(.PRE_W(PRE_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dec (
    .valid_i(txn_valid_i),
    .pre_i  (txn_pre_i),
    .addr_i (txn_addr_i),
    .wr_i   (txn_wr_i),
    .len_i  (txn_len_i),
    .dec_o  (dec)
  );

  rc_flag_reg #(.DATA_W(DATA_W), .N(NUM_EVT)) u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (evt_rise),
    .wr_en_i  (dec.wr_ok),
    .wr_data_i(txn_data_i),
    .q_o      (fault_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      wr_ack_o   <= 1'b0;
      wr_nack_o  <= 1'b0;
    end else begin
      rd_valid_o <= dec.rd;
      wr_ack_o   <= dec.wr_ok;
      wr_nack_o  <= dec.wr_bad;
      if (dec.rd) rd_data_o <= fault_o;
    end
  end
endmodule

// File: rtl/rc_chk.sv
module rc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mr_evt_i,
  input logic       wd_evt_i,
  input logic       lv1_evt_i,
  input logic       lv2_evt_i,
  input logic       txn_valid_i,
  input logic [3:0] txn_pre_i,
  input logic [7:0] txn_addr_i,
  input logic       txn_wr_i,
  input logic [3:0] txn_len_i,
  input logic [7:0] txn_data_i,
  input logic [7:0] fault_o,
  input logic       rd_valid_o,
  input logic [7:0] rd_data_o,
  input logic       wr_ack_o,
  input logic       wr_nack_o
);
  logic hit_c, wr_ok_c, wr_bad_c, rd_c, any_evt_c;
  assign hit_c     = txn_valid_i && txn_pre_i == 4'b1011 && txn_addr_i == 8'hFF;
  assign wr_ok_c   = hit_c && txn_wr_i && txn_len_i == 4'd1;
  assign wr_bad_c  = hit_c && txn_wr_i && txn_len_i != 4'd1;
  assign rd_c      = hit_c && !txn_wr_i;
  assign any_evt_c = mr_evt_i | wd_evt_i | lv1_evt_i | lv2_evt_i;

  // R2
  mr_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mr_evt_i) |=> fault_o[3]);
  // R2
  lv1_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lv1_evt_i) |=> fault_o[7]);
  // R3
  sticky_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ok_c |=> ((fault_o & $past(fault_o)) == $past(fault_o)));
  // R4
  unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o & 8'b0010_0111) == 8'h00);
  // R5
  no_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_c |=> !rd_valid_o && !wr_ack_o && !wr_nack_o);
  // R6
  wr_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok_c |=> wr_ack_o && !wr_nack_o);
  // R7
  nack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_bad_c && !any_evt_c |=> wr_nack_o && $stable(fault_o));
  // R8
  rd_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_c |=> rd_valid_o && rd_data_o == $past(fault_o));
  // R9
  evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok_c && $rose(wd_evt_i) |=> fault_o[4]);
endmodule

bind rc_cause_reg rc_chk u_chk (.*);

// File: tb/tb_rc_cause_reg.sv
module tb_rc_cause_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mr = 0, wd = 0, lv1 = 0, lv2 = 0;
  logic       tv = 0;
  logic [3:0] tpre = 0;
  logic [7:0] taddr = 0;
  logic       twr = 0;
  logic [3:0] tlen = 0;
  logic [7:0] tdata = 0;
  logic [7:0] fault, rdd;
  logic       rdv, ack, nack;

  int total = 0, bad = 0, cyc_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rc_cause_reg dut (
    .clk_i(clk), .rst_ni(rst_n),
    .mr_evt_i(mr), .wd_evt_i(wd), .lv1_evt_i(lv1), .lv2_evt_i(lv2),
    .txn_valid_i(tv), .txn_pre_i(tpre), .txn_addr_i(taddr), .txn_wr_i(twr),
    .txn_len_i(tlen), .txn_data_i(tdata),
    .fault_o(fault), .rd_valid_o(rdv), .rd_data_o(rdd),
    .wr_ack_o(ack), .wr_nack_o(nack)
  );

  // behavioural reference
  int m_fault = 0, m_rdd = 0;
  bit m_rdv = 0, m_ack = 0, m_nack = 0;
  bit m_prev [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fault = 0; m_rdd = 0; m_rdv = 0; m_ack = 0; m_nack = 0;
      foreach (m_prev[i]) m_prev[i] = 0;
    end else begin
      bit cur [4];
      int pos [4];
      bit hit;
      int nf;
      cur = '{mr, wd, lv2, lv1};
      pos = '{3, 4, 6, 7};
      hit = tv && tpre == 4'b1011 && taddr == 8'hFF;
      m_rdv  = hit && !twr;
      m_ack  = hit && twr && tlen == 1;
      m_nack = hit && twr && tlen != 1;
      if (m_rdv) m_rdd = m_fault;
      nf = m_ack ? (int'(tdata) & 'hD8) : m_fault;
      for (int i = 0; i < 4; i++) begin
        if (cur[i] && !m_prev[i]) nf = nf | (1 << pos[i]);
        m_prev[i] = cur[i];
      end
      m_fault = nf;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("model fault_o", int'(fault), m_fault);
      chk("model resp", {rdv, ack, nack}, {m_rdv, m_ack, m_nack});
      if (rdv) chk("model rd_data_o", int'(rdd), m_rdd);
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic txn(logic [3:0] p, logic [7:0] a, logic w, logic [3:0] l, logic [7:0] d);
    tv = 1; tpre = p; taddr = a; twr = w; tlen = l; tdata = d;
    step();
    tv = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<20000", cyc_cnt);
      finish_run();
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    chk("R1 fault_o reset", int'(fault), 0);
    chk("R1 responses reset", {rdv, ack, nack}, 0);

    txn(4'b1010, 8'hFF, 0, 0, 0);
    chk("R5 wrong preamble read", int'(rdv), 0);
    txn(4'b1011, 8'hFE, 0, 0, 0);
    chk("R5 wrong address read", int'(rdv), 0);

    mr = 1; step(); mr = 0;
    chk("R2 mr to bit3", int'(fault), 'h08);
    wd = 1; step(); wd = 0;
    chk("R2 wd to bit4", int'(fault), 'h18);
    lv2 = 1; step(); lv2 = 0;
    chk("R2 lv2 to bit6", int'(fault), 'h58);
    lv1 = 1; step(); lv1 = 0;
    chk("R2 lv1 to bit7", int'(fault), 'hD8);

    txn(4'b1011, 8'hFF, 0, 0, 0);
    chk("R8 read valid", int'(rdv), 1);
    chk("R8 read data", int'(rdd), 'hD8);

    txn(4'b1011, 8'h00, 1, 1, 8'h00);
    chk("R5 wrong address write ignored", int'(fault), 'hD8);
    chk("R5 wrong address no ack", int'(ack), 0);

    txn(4'b1011, 8'hFF, 1, 2, 8'h00);
    chk("R7 two-byte nack", int'(nack), 1);
    chk("R7 two-byte unchanged", int'(fault), 'hD8);
    txn(4'b1011, 8'hFF, 1, 0, 8'h00);
    chk("R7 zero-byte nack", int'(nack), 1);
    chk("R7 zero-byte unchanged", int'(fault), 'hD8);

    txn(4'b1011, 8'hFF, 1, 1, 8'h00);
    chk("R6 write ack", int'(ack), 1);
    chk("R6 write clears", int'(fault), 0);
    step();
    chk("R6 ack one cycle", int'(ack), 0);

    txn(4'b1011, 8'hFF, 1, 1, 8'hFF);
    chk("R4 unused bits masked", int'(fault), 'hD8);

    txn(4'b1011, 8'hFF, 1, 1, 8'h00);
    mr = 1; step();
    chk("R3 held level sets", int'(fault), 'h08);
    repeat (3) step();
    chk("R3 flag held", int'(fault), 'h08);
    txn(4'b1011, 8'hFF, 1, 1, 8'h00);
    chk("R3 cleared while high", int'(fault), 0);
    repeat (3) step();
    chk("R3 no retrigger while high", int'(fault), 0);
    mr = 0; step();
    chk("R3 level drop no effect", int'(fault), 0);

    wd = 1;
    txn(4'b1011, 8'hFF, 1, 1, 8'h00);
    wd = 0;
    chk("R9 event beats write", int'(fault), 'h10);
    mr = 1;
    txn(4'b1011, 8'hFF, 1, 1, 8'hC0);
    mr = 0;
    chk("R9 other bits take data", int'(fault), 'hC8);

    txn(4'b1011, 8'hFF, 1, 1, 8'h00);
    lv1 = 1;
    txn(4'b1011, 8'hFF, 0, 0, 0);
    lv1 = 0;
    chk("R8 read shows pre-edge value", int'(rdd), 0);
    chk("R2 lv1 during read", int'(fault), 'h80);

    for (int i = 0; i < 400; i++) begin
      mr = 1'($urandom_range(0, 1)); wd = 1'($urandom_range(0, 1));
      lv1 = 1'($urandom_range(0, 1)); lv2 = 1'($urandom_range(0, 1));
      tv = 1'($urandom_range(0, 1));
      tpre = ($urandom_range(0, 3) != 0) ? 4'b1011 : 4'($urandom_range(0, 15));
      taddr = ($urandom_range(0, 3) != 0) ? 8'hFF : 8'($urandom_range(0, 255));
      twr = 1'($urandom_range(0, 1));
      tlen = ($urandom_range(0, 2) != 0) ? 4'd1 : 4'($urandom_range(0, 15));
      tdata = 8'($urandom_range(0, 255));
      step();
    end
    tv = 0; mr = 0; wd = 0; lv1 = 0; lv2 = 0;
    step();
    finish_run();
  end
endmodule